// File: doc/BRIEF.md
# Immediate Trap Condition Unit

This block sits beside the integer execute stage of a 64-bit core. It looks at each instruction that issue marks valid and decides whether that instruction is one of the six register-against-immediate conditional traps. If it is, the block evaluates the trap condition and raises a trap request, tagged with the trap cause code, one clock later. The block takes the instruction word and the 64-bit operand already read from the source register. The source register index is decoded elsewhere, and this block ignores it.

The 16-bit immediate is always sign-extended to 64 bits. A single 65-bit subtractor then produces the equality, signed-less-than and unsigned-less-than flags. The sub-opcode chooses one of these flags, or its inverse. Some encodings fall inside the trap sub-opcode group but name none of the six forms. For these the block raises a reserved-instruction flag in place of a trap. The exception logic downstream handles vectoring and the updates to its status registers.

Top module: `trapi_unit`

## Requirements
- R1: While rst_n is low, trap_req, rsvd_op and trap_cause are all zero, whatever the inputs are.
- R2: If instr[31:26] is 000001 and instr[20:16] is 01000, a trap is raised when rs_val is greater than or equal to the sign-extended instr[15:0], with both read as signed.
- R3: If instr[31:26] is 000001 and instr[20:16] is 01001, a trap is raised when rs_val is greater than or equal to the sign-extended instr[15:0], with both read as unsigned.
- R4: If instr[31:26] is 000001 and instr[20:16] is 01010, a trap is raised when rs_val is less than the sign-extended immediate, with both read as signed.
- R5: If instr[31:26] is 000001 and instr[20:16] is 01011, a trap is raised when rs_val is less than the sign-extended immediate, with both read as unsigned.
- R6: If instr[31:26] is 000001 and instr[20:16] is 01100, a trap is raised when rs_val equals the sign-extended immediate.
- R7: If instr[31:26] is 000001 and instr[20:16] is 01110, a trap is raised when rs_val differs from the sign-extended immediate.
- R8: If instr[31:26] is 000001 and instr[20:16] is 01101 or 01111, rsvd_op is raised and trap_req stays low.
- R9: Any other opcode, or an instr[20:16] outside 01xxx, raises neither trap_req nor rsvd_op.
- R10: When instr_vld is low, trap_req and rsvd_op are low in the next cycle, whatever the operand values are.
- R11: An instruction presented at clock edge N has its result on the outputs after edge N. trap_cause reads 13 whenever trap_req is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| instr_vld | input | 1 | Instruction word and operand are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 64 | Value of the source register |
| trap_req | output | 1 | Registered trap exception request |
| trap_cause | output | 5 | Cause code accompanying the request (13), zero when idle |
| rsvd_op | output | 1 | Registered reserved-instruction flag |

## Verification
The assertions assume that instr_vld is a known 0 or 1 at every sampled edge after reset, and that instr and rs_val are known whenever instr_vld is high. They also assume that rst_n rises only while instr_vld is low, so that the synchronizer delay hides no instruction. The bench changes every input only on the falling clock edge. It holds instr_vld low through the release of reset. It never drives X, even when instr_vld is low and the word is ignored. Directed operands cover sign-boundary and equal values, and the random operands are biased toward the extended immediate.

// File: rtl/trapi_pkg.sv
package trapi_pkg;

  localparam int XLEN    = 64;
  localparam int IMM_W   = 16;
  localparam int OPC_W   = 6;
  localparam int SUB_W   = 5;
  localparam int CAUSE_W = 5;

  // instruction field positions
  localparam int OPC_LSB = 26;
  localparam int SUB_LSB = 16;
  localparam int IMM_LSB = 0;

  localparam logic [OPC_W-1:0]   OPC_REGIMM = 6'b000001;
  localparam logic [1:0]         SUB_GROUP  = 2'b01;
  localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 5'd13;

  localparam logic [SUB_W-1:0] SUB_GE_S = 5'b01000;
  localparam logic [SUB_W-1:0] SUB_GE_U = 5'b01001;
  localparam logic [SUB_W-1:0] SUB_LT_S = 5'b01010;
  localparam logic [SUB_W-1:0] SUB_LT_U = 5'b01011;
  localparam logic [SUB_W-1:0] SUB_EQ   = 5'b01100;
  localparam logic [SUB_W-1:0] SUB_NE   = 5'b01110;

  typedef enum logic [2:0] {
    TK_NONE,
    TK_GE_S,
    TK_GE_U,
    TK_LT_S,
    TK_LT_U,
    TK_EQ,
    TK_NE
  } trap_kind_e;

  typedef struct packed {
    logic eq;
    logic lt_s;
    logic lt_u;
  } cmp_flags_t;

endpackage

// File: rtl/trapi_rst_sync.sv
module trapi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/trapi_decode.sv
module trapi_decode
  import trapi_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int IW  = IMM_W
) (
  input  logic [31:0]  instr,
  output trap_kind_e   kind,
  output logic         rsvd,
  output logic         regimm,
  output logic [W-1:0] imm_x
);
  localparam int PAD = W - IW;

  logic [OPC_W-1:0] opc;
  logic [SUB_W-1:0] sub;
  logic [IW-1:0]    imm;
  logic             in_grp;
  trap_kind_e       kind_raw;

  assign opc    = instr[OPC_LSB +: OPC_W];
  assign sub    = instr[SUB_LSB +: SUB_W];
  assign imm    = instr[IMM_LSB +: IW];
  assign regimm = (opc == OPC_REGIMM);
  assign in_grp = (sub[SUB_W-1 -: 2] == SUB_GROUP);

  // every form, signed or unsigned, uses the sign-extended immediate
  generate
    if (PAD > 0) begin : g_pad
      assign imm_x = {{PAD{imm[IW-1]}}, imm};
    end else begin : g_nopad
      assign imm_x = imm[W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sub)
      SUB_GE_S: kind_raw = TK_GE_S;
      SUB_GE_U: kind_raw = TK_GE_U;
      SUB_LT_S: kind_raw = TK_LT_S;
      SUB_LT_U: kind_raw = TK_LT_U;
      SUB_EQ:   kind_raw = TK_EQ;
      SUB_NE:   kind_raw = TK_NE;
      default:  kind_raw = TK_NONE;
    endcase
  end

  always_comb begin
    kind = regimm ? kind_raw : TK_NONE;
    rsvd = regimm && in_grp && (kind_raw == TK_NONE);
  end
endmodule

// File: rtl/trapi_compare.sv
module trapi_compare
  import trapi_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmp_flags_t   flags
);
  logic [W:0] diff;
  logic       sgn_differ;

  // one subtractor serves equality, signed and unsigned ordering
  assign diff       = {1'b0, a} - {1'b0, b};
  assign sgn_differ = a[W-1] ^ b[W-1];

  always_comb begin
    flags.lt_u = diff[W];
    flags.lt_s = sgn_differ ? a[W-1] : diff[W];
    flags.eq   = ~|diff;
  end
endmodule

// File: rtl/trapi_select.sv
module trapi_select
  import trapi_pkg::*;
(
  input  trap_kind_e kind,
  input  cmp_flags_t flags,
  output logic       hit
);
  always_comb begin
    unique case (kind)
      TK_GE_S: hit = ~flags.lt_s;
      TK_GE_U: hit = ~flags.lt_u;
      TK_LT_S: hit =  flags.lt_s;
      TK_LT_U: hit =  flags.lt_u;
      TK_EQ:   hit =  flags.eq;
      TK_NE:   hit = ~flags.eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/trapi_unit.sv
module trapi_unit
  import trapi_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int SYNC_ST = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_vld,
  input  logic [31:0]        instr,
  input  logic [W-1:0]       rs_val,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               rsvd_op
);
  logic               rst_n_s;
  trap_kind_e         kind;
  logic               rsvd_dec;
  logic               regimm;
  logic [W-1:0]       imm_x;
  cmp_flags_t         flags;
  logic               hit;

  logic               trap_d,  trap_q;
  logic               rsvd_d,  rsvd_q;
  logic [CAUSE_W-1:0] cause_d, cause_q;
  logic               upd_en;

  trapi_rst_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  trapi_decode #(.W(W), .IW(IMM_W)) u_dec (
    .instr  (instr),
    .kind   (kind),
    .rsvd   (rsvd_dec),
    .regimm (regimm),
    .imm_x  (imm_x)
  );

  trapi_compare #(.W(W)) u_cmp (
    .a     (rs_val),
    .b     (imm_x),
    .flags (flags)
  );

  trapi_select u_sel (
    .kind  (kind),
    .flags (flags),
    .hit   (hit)
  );

  // next-state
  always_comb begin
    trap_d  = instr_vld && hit;
    rsvd_d  = instr_vld && rsvd_dec;
    cause_d = trap_d ? CAUSE_TRAP : '0;
    upd_en  = instr_vld || trap_q || rsvd_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      trap_q  <= 1'b0;
      rsvd_q  <= 1'b0;
      cause_q <= '0;
    end else if (upd_en) begin
      trap_q  <= trap_d;
      rsvd_q  <= rsvd_d;
      cause_q <= cause_d;
    end
  end

  assign trap_req   = trap_q;
  assign rsvd_op    = rsvd_q;
  assign trap_cause = cause_q;

  // R10: an idle cycle leaves both outputs low afterwards
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    !instr_vld |=> (!trap_req && !rsvd_op));

  // R11: the cause travels with the request
  a_r11_cause_on_trap: assert property (@(posedge clk) disable iff (!rst_n_s)
    trap_req |-> (trap_cause == 5'd13));

  a_r11_cause_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    !trap_req |-> (trap_cause == '0));

  // R8: reserved encodings never trap
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsvd_op |-> !trap_req);

  // R9: a foreign opcode produces nothing
  a_r9_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (instr_vld && !regimm) |=> (!trap_req && !rsvd_op));

  // R6: equality excludes both orderings from the shared comparator
  a_r6_eq_not_less: assert property (@(posedge clk) disable iff (!rst_n_s)
    (instr_vld && flags.eq) |-> (!flags.lt_s && !flags.lt_u));

  // R4: with matching sign bits signed and unsigned ordering agree
  a_r4_same_sign_agree: assert property (@(posedge clk) disable iff (!rst_n_s)
    (instr_vld && (rs_val[W-1] == imm_x[W-1])) |-> (flags.lt_s == flags.lt_u));

  // R1/R11: a registered event always had a valid instruction one cycle earlier
  a_r11_needs_valid: assert property (@(posedge clk) disable iff (!rst_n_s)
    (trap_req || rsvd_op) |-> $past(instr_vld));
endmodule

// File: tb/trapi_unit_tb_top.sv
module trapi_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_vld;
  logic [31:0] instr;
  logic [63:0] rs_val;
  logic        trap_req;
  logic [4:0]  trap_cause;
  logic        rsvd_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    t;
    bit    r;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  trapi_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_vld  (instr_vld),
    .instr      (instr),
    .rs_val     (rs_val),
    .trap_req   (trap_req),
    .trap_cause (trap_cause),
    .rsvd_op    (rsvd_op)
  );

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] sub, logic [15:0] imm);
    return {op, 5'd7, sub, imm};
  endfunction

  function automatic void ref_model(bit v, logic [31:0] iw, logic [63:0] x,
                                    output bit t, output bit r, output string tag);
    longint      si;
    logic [63:0] ui;
    longint      sx;
    si  = longint'($signed(iw[15:0]));
    ui  = si;
    sx  = x;
    t   = 1'b0;
    r   = 1'b0;
    tag = "R9";
    if (!v) begin
      tag = "R10";
      return;
    end
    if (iw[31:26] != 6'b000001) return;
    case (iw[20:16])
      5'b01000: begin tag = "R2"; t = (sx >= si); end
      5'b01001: begin tag = "R3"; t = (x >= ui);  end
      5'b01010: begin tag = "R4"; t = (sx < si);  end
      5'b01011: begin tag = "R5"; t = (x < ui);   end
      5'b01100: begin tag = "R6"; t = (x == ui);  end
      5'b01110: begin tag = "R7"; t = (x != ui);  end
      5'b01101, 5'b01111: begin tag = "R8"; r = 1'b1; end
      default: ;
    endcase
  endfunction

  task automatic check_head();
    exp_t        e;
    logic [4:0]  ec;
    if (q.size() == 0) return;
    e  = q.pop_front();
    ec = e.t ? 5'd13 : 5'd0;
    checks++;
    if (trap_req !== e.t || rsvd_op !== e.r || trap_cause !== ec) begin
      fails++;
      $display("FAIL %s/R11 actual trap=%b rsvd=%b cause=%0d expected trap=%b rsvd=%b cause=%0d",
               e.tag, trap_req, rsvd_op, trap_cause, e.t, e.r, ec);
    end
  endtask

  task automatic step(bit v, logic [31:0] iw, logic [63:0] x);
    exp_t e;
    @(negedge clk);
    check_head();
    instr_vld = v;
    instr     = iw;
    rs_val    = x;
    ref_model(v, iw, x, e.t, e.r, e.tag);
    q.push_back(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    instr_vld = 1'b0;
    instr     = '0;
    rs_val    = '0;
    // R1: outputs stay clear in reset even with a trapping instruction applied
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (trap_req !== 1'b0 || rsvd_op !== 1'b0 || trap_cause !== 5'd0) begin
        fails++;
        $display("FAIL R1 actual trap=%b rsvd=%b cause=%0d expected 0 0 0",
                 trap_req, rsvd_op, trap_cause);
      end
      instr_vld = 1'b1;
      instr     = mk(6'b000001, 5'b01100, 16'h0000);
      rs_val    = '0;
    end
    @(negedge clk);
    instr_vld = 1'b0;
    rst_n     = 1'b1;
    repeat (4) @(negedge clk);

    // R2 signed greater-or-equal
    step(1, mk(6'b000001, 5'b01000, 16'hFFFF), 64'hFFFF_FFFF_FFFF_FFFF);
    step(1, mk(6'b000001, 5'b01000, 16'hFFFF), 64'hFFFF_FFFF_FFFF_FFFE);
    step(1, mk(6'b000001, 5'b01000, 16'h7FFF), 64'h0000_0000_0000_7FFF);
    // R3 unsigned greater-or-equal against sign-extended immediate
    step(1, mk(6'b000001, 5'b01001, 16'hFFFF), 64'hFFFF_FFFF_FFFF_FFFF);
    step(1, mk(6'b000001, 5'b01001, 16'hFFFF), 64'h7FFF_FFFF_FFFF_FFFF);
    step(1, mk(6'b000001, 5'b01001, 16'h0010), 64'h8000_0000_0000_0000);
    // R4 signed less-than
    step(1, mk(6'b000001, 5'b01010, 16'hFFFF), 64'd5);
    step(1, mk(6'b000001, 5'b01010, 16'h0000), 64'h8000_0000_0000_0000);
    // R5 unsigned less-than
    step(1, mk(6'b000001, 5'b01011, 16'hFFFF), 64'd5);
    step(1, mk(6'b000001, 5'b01011, 16'h0000), 64'h8000_0000_0000_0000);
    // R6 equality with high bits from the extension
    step(1, mk(6'b000001, 5'b01100, 16'h8000), 64'hFFFF_FFFF_FFFF_8000);
    step(1, mk(6'b000001, 5'b01100, 16'h8000), 64'h0000_0000_0000_8000);
    // R7 inequality
    step(1, mk(6'b000001, 5'b01110, 16'h8000), 64'h0000_0000_0000_8000);
    step(1, mk(6'b000001, 5'b01110, 16'h1234), 64'h0000_0000_0000_1234);
    // R8 reserved encodings in the group
    step(1, mk(6'b000001, 5'b01101, 16'h0000), 64'd0);
    step(1, mk(6'b000001, 5'b01111, 16'h0000), 64'd1);
    // R9 other opcode, and regimm outside the group
    step(1, mk(6'b000000, 5'b01100, 16'h0000), 64'd0);
    step(1, mk(6'b000001, 5'b00000, 16'h0000), 64'd0);
    step(1, mk(6'b000001, 5'b11101, 16'h0000), 64'd0);
    // R10 valid low with trapping and reserved words
    step(0, mk(6'b000001, 5'b01100, 16'h0000), 64'd0);
    step(0, mk(6'b000001, 5'b01101, 16'h0000), 64'd0);
    // R11 back-to-back traps each land one cycle later
    step(1, mk(6'b000001, 5'b01110, 16'h0001), 64'd0);
    step(1, mk(6'b000001, 5'b01110, 16'h0001), 64'd1);
    step(1, mk(6'b000001, 5'b01110, 16'h0001), 64'd2);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0]  op;
      logic [4:0]  sub;
      logic [15:0] imm;
      logic [63:0] x;
      int          sel;
      op  = ($urandom_range(0, 5) == 0) ? 6'($urandom) : 6'b000001;
      sel = $urandom_range(0, 9);
      case (sel)
        0: sub = 5'b01000;
        1: sub = 5'b01001;
        2: sub = 5'b01010;
        3: sub = 5'b01011;
        4: sub = 5'b01100;
        5: sub = 5'b01110;
        6: sub = 5'b01101;
        7: sub = 5'b01111;
        default: sub = 5'($urandom);
      endcase
      imm = 16'($urandom);
      case ($urandom_range(0, 3))
        0: x = {{48{imm[15]}}, imm};
        1: x = {{48{imm[15]}}, imm} + 64'($signed(2'($urandom)) );
        2: x = {$urandom, $urandom};
        default: x = {{48{$urandom_range(0, 1) == 1}}, 16'($urandom)};
      endcase
      step($urandom_range(0, 7) != 0, {op, 5'($urandom), sub, imm}, x);
    end
    step(0, '0, '0);
    @(negedge clk);
    check_head();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule